// File: doc/BRIEF.md
# Next Program Counter Selection Unit

This block keeps the program counter of a multicycle processor and decides, once per cycle, whether and how it changes. Three candidate next values exist: the live ALU result (the incremented address during fetch), a registered ALU output (a branch target worked out one step earlier), and a jump target built from the top bits of the current counter and a 26-bit field taken from the instruction.

A two-bit source select picks among the candidates. Two enables decide whether the counter loads. One enable forces an unconditional load, used for sequential increment and for jumps. The other loads only when the ALU zero flag is high, which means the two compared registers were equal. The select code 3 is reserved and never changes the counter. The sequencer that drives these controls lies outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter becomes 32'h0000_0000 after that edge.
- R2: With `src_sel`=2'b00 and `ld_uncond`=1, the counter takes `alu_res` at the next rising edge.
- R3: With `src_sel`=2'b01 and the load enabled, the counter takes `alu_reg` at the next rising edge.
- R4: With `src_sel`=2'b10 and the load enabled, the counter takes {pc[31:28], `jmp_field`, 2'b00} at the next rising edge. The upper four bits come from the counter value held before that edge.
- R5: With `ld_cond`=1, `ld_uncond`=0 and `alu_zero`=1, the counter loads the selected source. If `alu_zero`=0 instead, the counter keeps its value.
- R6: With `ld_uncond`=0 and `ld_cond`=0, the counter keeps its value for every source select and flag value.
- R7: With `src_sel`=2'b11, the counter keeps its value even when an enable is active.
- R8: `ld_uncond`=1 loads whatever `alu_zero` and `ld_cond` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | 32 | Live ALU result, the incremented address during fetch |
| alu_reg | input | 32 | Registered ALU output holding the branch target |
| alu_zero | input | 1 | ALU zero flag, high when the compared values are equal |
| jmp_field | input | 26 | Word-address field of a jump instruction |
| src_sel | input | 2 | Next-value source: 0 ALU, 1 ALU register, 2 jump, 3 reserved |
| ld_uncond | input | 1 | Unconditional load enable |
| ld_cond | input | 1 | Load enable qualified by `alu_zero` |
| pc | output | 32 | Current program counter |

## Verification
All selection and enable logic is combinational and feeds one register. Any control or data stimulus therefore shows up on `pc` exactly one rising edge later, and never in the same cycle. The bench drives inputs on the falling edge and samples `pc` on the next falling edge, half a period after the rising edge that loads it. That is the first point where the result is due and the point where it is stable. For hold cases the bench compares `pc` with the value it held before the edge.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int ADDR_W   = 32;
    localparam int JFIELD_W = 26;
    localparam int SEL_W    = 2;
    localparam int ALIGN_W  = 2;
    localparam int PAGE_W   = ADDR_W - JFIELD_W - ALIGN_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [SEL_W-1:0] {
        SRC_ALU  = 2'b00,
        SRC_AREG = 2'b01,
        SRC_JUMP = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    typedef struct packed {
        logic  valid;
        addr_t value;
    } cand_t;

    typedef struct packed {
        logic uncond;
        logic cond;
        logic zero;
    } ld_ctl_t;

    function automatic addr_t form_jump(addr_t cur, logic [JFIELD_W-1:0] fld);
        return {cur[ADDR_W-1 -: PAGE_W], fld, {ALIGN_W{1'b0}}};
    endfunction

    function automatic logic load_ok(ld_ctl_t c);
        return c.uncond | (c.cond & c.zero);
    endfunction

endpackage

// File: rtl/npc_src_mux.sv
module npc_src_mux
    import npc_pkg::*;
(
    input  addr_t                cur_pc,
    input  addr_t                alu_res,
    input  addr_t                alu_reg,
    input  logic [JFIELD_W-1:0]  jmp_field,
    input  src_e                 sel,
    output cand_t                cand
);
    always_comb begin
        cand = '{valid: 1'b0, value: cur_pc};
        unique case (sel)
            SRC_ALU:  cand = '{valid: 1'b1, value: alu_res};
            SRC_AREG: cand = '{valid: 1'b1, value: alu_reg};
            SRC_JUMP: cand = '{valid: 1'b1, value: form_jump(cur_pc, jmp_field)};
            default:  cand = '{valid: 1'b0, value: cur_pc};
        endcase
    end
endmodule

// File: rtl/npc_load_ctl.sv
module npc_load_ctl
    import npc_pkg::*;
(
    input  ld_ctl_t ctl,
    input  logic    cand_valid,
    output logic    load
);
    assign load = cand_valid & load_ok(ctl);
endmodule

// File: rtl/npc_reg.sv
module npc_reg
    import npc_pkg::*;
#(
    parameter addr_t RESET_VAL = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t nxt,
    output addr_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= RESET_VAL;
        else if (load) q <= nxt;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] alu_res,
    input  logic [31:0] alu_reg,
    input  logic        alu_zero,
    input  logic [25:0] jmp_field,
    input  logic [1:0]  src_sel,
    input  logic        ld_uncond,
    input  logic        ld_cond,
    output logic [31:0] pc
);
    cand_t   cand;
    ld_ctl_t ctl;
    logic    load;
    addr_t   cur;

    assign ctl = '{uncond: ld_uncond, cond: ld_cond, zero: alu_zero};

    npc_src_mux u_mux (
        .cur_pc    (cur),
        .alu_res   (alu_res),
        .alu_reg   (alu_reg),
        .jmp_field (jmp_field),
        .sel       (src_e'(src_sel)),
        .cand      (cand)
    );

    npc_load_ctl u_ctl (
        .ctl        (ctl),
        .cand_valid (cand.valid),
        .load       (load)
    );

    npc_reg #(.RESET_VAL('0)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .nxt  (cand.value),
        .q    (cur)
    );

    assign pc = cur;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] alu_res,
    input logic [31:0] alu_reg,
    input logic        alu_zero,
    input logic [25:0] jmp_field,
    input logic [1:0]  src_sel,
    input logic        ld_uncond,
    input logic        ld_cond,
    input logic [31:0] pc
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> pc == 32'h0);

    assert_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00 && ld_uncond) |=> pc == $past(alu_res));

    assert_branch_R3: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b01 && (ld_uncond || (ld_cond && alu_zero))) |=> pc == $past(alu_reg));

    assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b10 && ld_uncond) |=> pc == {$past(pc[31:28]), $past(jmp_field), 2'b00});

    assert_cond_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (!ld_uncond && ld_cond && !alu_zero) |=> $stable(pc));

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld_uncond && !ld_cond) |=> $stable(pc));

    assert_reserved_R7: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b11) |=> $stable(pc));
endmodule

bind npc_unit npc_unit_chk u_chk (.*);

// File: tb/npc_unit_test.sv
module npc_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] alu_res, alu_reg;
    logic        alu_zero;
    logic [25:0] jmp_field;
    logic [1:0]  src_sel;
    logic        ld_uncond, ld_cond;
    logic [31:0] pc;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    npc_unit uut (.*);

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive at negedge, one rising edge, sample at next negedge
    task automatic step(logic [1:0] s, logic u, logic c, logic z,
                        logic [31:0] ar, logic [31:0] ag, logic [25:0] j);
        src_sel = s; ld_uncond = u; ld_cond = c; alu_zero = z;
        alu_res = ar; alu_reg = ag; jmp_field = j;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        src_sel = 2'b00; ld_uncond = 0; ld_cond = 0; alu_zero = 0;
        alu_res = '0; alu_reg = '0; jmp_field = '0;
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs();
        @(negedge clk); @(negedge clk);
        check("R1", pc, 32'h0);
        step(2'b00, 1, 0, 0, 32'h40, 0, 0);
        rst = 1;
        step(2'b00, 1, 0, 0, 32'h80, 0, 0);
        check("R1 reset wins over load", pc, 32'h0);
        rst = 0;
    endtask

    task automatic t_increment();
        logic [31:0] p;
        for (int i = 0; i < 4; i++) begin
            p = pc;
            step(2'b00, 1, 0, 0, p + 4, 32'hDEAD_BEEF, 26'h3FF_FFFF);
            check("R2", pc, p + 4);
        end
    endtask

    task automatic t_branch();
        logic [31:0] p;
        step(2'b01, 0, 1, 1, 32'h1111_1111, 32'h0000_1200, 0);
        check("R3 R5 taken", pc, 32'h0000_1200);
        p = pc;
        step(2'b01, 0, 1, 0, 32'h1111_1111, 32'h0000_5550, 0);
        check("R5 not taken", pc, p);
        step(2'b01, 1, 0, 0, 0, 32'h0000_2000, 0);
        check("R3 uncond", pc, 32'h0000_2000);
    endtask

    task automatic t_jump();
        step(2'b00, 1, 0, 0, 32'hA000_0010, 0, 0);
        check("R2 setup", pc, 32'hA000_0010);
        step(2'b10, 1, 0, 0, 32'h5555_5555, 32'h6666_6666, 26'h3AB_CDEF);
        check("R4", pc, {4'hA, 26'h3AB_CDEF, 2'b00});
        step(2'b10, 1, 0, 0, 0, 0, 26'h000_0001);
        check("R4 page kept", pc, 32'hA000_0004);
    endtask

    task automatic t_hold();
        logic [31:0] p;
        p = pc;
        for (int s = 0; s < 4; s++) begin
            step(s[1:0], 0, 0, 1, 32'h1234_5678, 32'h8765_4321, 26'h155_5555);
            check("R6", pc, p);
        end
        step(2'b11, 1, 1, 1, 32'h1234_5678, 32'h8765_4321, 26'h155_5555);
        check("R7 uncond", pc, p);
        step(2'b11, 0, 1, 1, 32'h1234_5678, 32'h8765_4321, 26'h155_5555);
        check("R7 cond", pc, p);
    endtask

    task automatic t_uncond_override();
        step(2'b00, 1, 1, 0, 32'h0000_3000, 0, 0);
        check("R8 zero low", pc, 32'h0000_3000);
        step(2'b01, 1, 0, 1, 0, 32'h0000_3400, 0);
        check("R8 cond off", pc, 32'h0000_3400);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_increment();
        t_branch();
        t_jump();
        t_hold();
        t_uncond_override();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule